// File: doc/BRIEF.md
# Dead-Band Generator with Independent Edge Delays

This block turns two raw PWM levels into a pair of gate-drive outputs separated by dead time. It has two delay paths. One delays only the rising edges of its source. The other delays only the falling edges of its source. Each path has its own programmable count in clock cycles. Three 2-bit mode fields set three things: which raw input feeds each path, whether each delayed level is inverted on its way out, and whether each output takes the delayed level or passes its raw input through unchanged.

The paths qualify edges and do not queue them. A level has to persist for the whole programmed count before the delayed edge appears. If the source changes back sooner, the path throws the pending edge away and starts counting again from the next qualifying edge. As a result, a high pulse shorter than the rising delay disappears. A low gap shorter than the falling delay is bridged and the output stays high. Output edges never come out in a different order from the input edges.

Top module: `dead_band_gen`

## Requirements
- R1: While rst_n is low at a clock edge, both delay paths clear to level 0. In the complementary delayed setting (src_mode 2, pol_mode 2, out_mode 3) with raw_a low, this gives pwm_a = 0 and pwm_b = 1.
- R2: src_mode bit 0 selects the source of the rising path (0 = raw_a, 1 = raw_b). src_mode bit 1 selects the source of the falling path (0 = raw_a, 1 = raw_b). So code 2 feeds raw_a to the rising path and raw_b to the falling path.
- R3: pol_mode bit 0 inverts the rising-path level driven onto pwm_a. pol_mode bit 1 inverts the falling-path level driven onto pwm_b. Code 2 is active-high complementary.
- R4: out_mode bit 1 set makes pwm_a take the rising path, otherwise pwm_a equals raw_a. out_mode bit 0 set makes pwm_b take the falling path, otherwise pwm_b equals raw_b. A bypassed output ignores pol_mode. Code 3 uses both paths and code 0 bypasses both.
- R5: The rising path goes high at the (rise_dly+1)-th consecutive clock edge at which its source is sampled high. It goes low at the first edge at which its source is sampled low.
- R6: The falling path goes low at the (fall_dly+1)-th consecutive clock edge at which its source is sampled low. It goes high at the first edge at which its source is sampled high.
- R7: A source high pulse lasting L sampled edges, with L <= rise_dly, leaves the rising path low. With L > rise_dly the path is high for L - rise_dly cycles. A later pulse is timed from its own start.
- R8: A source low gap lasting L sampled edges, with L <= fall_dly, leaves the falling path high.
- R9: A delay count of 0 makes the path follow its source at the next clock edge.
- R10: When both paths take raw_a and the outputs are complementary delayed (src_mode 0, pol_mode 2, out_mode 3), pwm_a and pwm_b are never high together, whatever the pulse widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_a | input | 1 | Raw PWM level A |
| raw_b | input | 1 | Raw PWM level B |
| rise_dly | input | 10 | Rising-edge delay in clock cycles |
| fall_dly | input | 10 | Falling-edge delay in clock cycles |
| src_mode | input | 2 | Source selection for the two delay paths |
| pol_mode | input | 2 | Inversion of each delayed level |
| out_mode | input | 2 | Delayed or bypassed choice for each output |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The only state inside the block is a saturating counter and a level register in each path. A counter that is not cleared when its source changes shows up at the ports as an edge that arrives early or a short pulse that leaks through. A level register that does not drop at once shows up as an output staying high one cycle too long. Both appear in the first cycle after the source edge, or after the programmed count, so a per-cycle comparison catches them within one pulse. The narrow-pulse sweeps around the delay value, together with the no-overlap property, show any reordering of edges in the same cycle it happens.

// File: rtl/db_pkg.sv
// Shared widths and mode codes for the dead-band generator.
package db_pkg;
    localparam int DB_DLY_W = 10;

    typedef logic [1:0] db_mode_t;

    localparam db_mode_t DB_SRC_A_ONLY  = 2'd0;
    localparam db_mode_t DB_POL_AHC     = 2'd2;
    localparam db_mode_t DB_OUT_DELAYED = 2'd3;
endpackage

// File: rtl/db_delay_path.sv
// One edge-qualifying delay path.
// The level HOLD_LVL passes to dq only after din has stayed at HOLD_LVL
// for dly+1 consecutive clock edges. The opposite level passes at the
// next edge, and that also clears the count.
// Assumes: dly is compared live; callers change it only while idle.
module db_delay_path #(
    parameter int DLY_W    = 10,
    parameter bit HOLD_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [DLY_W-1:0] dly,
    output logic             dq
);
    localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

    logic [DLY_W-1:0] cnt;

    // Count consecutive HOLD_LVL samples and release the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dq  <= 1'b0;
        end else if (din != HOLD_LVL) begin
            cnt <= '0;
            dq  <= ~HOLD_LVL;
        end else if (cnt >= dly) begin
            dq  <= HOLD_LVL;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // R5 / R6: the non-delayed level follows at the next edge.
    assert_release_next_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (din != HOLD_LVL) |=> (dq != HOLD_LVL));

    // R9: zero count passes the delayed level at the next edge.
    assert_zero_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dly == '0 && din == HOLD_LVL) |=> (dq == HOLD_LVL));

    // R7 / R8: the delayed level never appears unless the source held it.
    assert_no_early_edge_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dq == HOLD_LVL && $past(dq) != HOLD_LVL) |-> ($past(din) == HOLD_LVL));
endmodule

// File: rtl/db_out_stage.sv
// Output stage for one pin: optional inversion of a delayed level, or a
// plain pass-through of the raw input when the delay path is bypassed.
// Assumes: bypass ignores the inversion control.
module db_out_stage (
    input  logic raw,
    input  logic path_q,
    input  logic inv,
    input  logic use_path,
    output logic y
);
    // Choose the delayed (optionally inverted) level or the raw level.
    always_comb begin
        y = use_path ? (path_q ^ inv) : raw;
    end
endmodule

// File: rtl/dead_band_gen.sv
// Dead-band generator top.
// Index 0 is the rising-edge path that drives pwm_a.
// Index 1 is the falling-edge path that drives pwm_b.
// Assumes: the mode fields and delay counts are quasi-static, set by the
// surrounding control logic.
module dead_band_gen
    import db_pkg::*;
#(
    parameter int DLY_W = DB_DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_a,
    input  logic             raw_b,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    input  logic [1:0]       src_mode,
    input  logic [1:0]       pol_mode,
    input  logic [1:0]       out_mode,
    output logic             pwm_a,
    output logic             pwm_b
);
    localparam int NPATH = 2;

    logic [NPATH-1:0] path_src;
    logic [NPATH-1:0] path_q;
    logic [NPATH-1:0] raw_v;
    logic [NPATH-1:0] use_v;
    logic [NPATH-1:0] y_v;
    logic [DLY_W-1:0] path_dly [NPATH];

    // Route each raw input to the path its source-select bit names.
    always_comb begin
        path_src[0] = src_mode[0] ? raw_b : raw_a;
        path_src[1] = src_mode[1] ? raw_b : raw_a;
        path_dly[0] = rise_dly;
        path_dly[1] = fall_dly;
        raw_v       = {raw_b, raw_a};
        use_v       = {out_mode[0], out_mode[1]};
    end

    for (genvar i = 0; i < NPATH; i++) begin : g_path
        db_delay_path #(
            .DLY_W   (DLY_W),
            .HOLD_LVL(i == 0)
        ) u_path (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (path_src[i]),
            .dly  (path_dly[i]),
            .dq   (path_q[i])
        );

        db_out_stage u_out (
            .raw     (raw_v[i]),
            .path_q  (path_q[i]),
            .inv     (pol_mode[i]),
            .use_path(use_v[i]),
            .y       (y_v[i])
        );
    end

    // Map the per-path results onto the output pins.
    always_comb begin
        pwm_a = y_v[0];
        pwm_b = y_v[1];
    end

    // R10: with one shared source, complementary delayed outputs never overlap.
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_mode == DB_SRC_A_ONLY && $past(src_mode) == DB_SRC_A_ONLY &&
         pol_mode == DB_POL_AHC && out_mode == DB_OUT_DELAYED) |-> !(pwm_a && pwm_b));
endmodule

// File: tb/dead_band_gen_test.sv
// Scoreboard bench: a driver steps inputs at the falling clock edge and
// queues the outputs expected after the next rising edge. A monitor pops
// one item per cycle and compares.
module dead_band_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_a = 1'b0;
    logic       raw_b = 1'b0;
    logic [9:0] rise_dly = 10'd5;
    logic [9:0] fall_dly = 10'd5;
    logic [1:0] src_mode = 2'd2;
    logic [1:0] pol_mode = 2'd2;
    logic [1:0] out_mode = 2'd3;
    logic       pwm_a;
    logic       pwm_b;

    // Values applied at the next driver step.
    logic       nx_rst = 1'b0;
    logic [9:0] nx_rd = 10'd5;
    logic [9:0] nx_fd = 10'd5;
    logic [1:0] nx_src = 2'd2;
    logic [1:0] nx_pol = 2'd2;
    logic [1:0] nx_out = 2'd3;

    typedef struct {
        logic  a;
        logic  b;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   hi_run = 0;
    int   lo_run = 100000;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    dead_band_gen uut (
        .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b),
        .rise_dly(rise_dly), .fall_dly(fall_dly),
        .src_mode(src_mode), .pol_mode(pol_mode), .out_mode(out_mode),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // One cycle: apply inputs, predict the outputs from run lengths.
    task automatic step(input logic ia, input logic ib, input string tag);
        exp_t e;
        logic rs, fs, rq, fq;
        @(negedge clk);
        rst_n = nx_rst; rise_dly = nx_rd; fall_dly = nx_fd;
        src_mode = nx_src; pol_mode = nx_pol; out_mode = nx_out;
        raw_a = ia; raw_b = ib;
        rs = src_mode[0] ? ib : ia;
        fs = src_mode[1] ? ib : ia;
        if (!rst_n) begin
            hi_run = 0; lo_run = 100000; rq = 1'b0; fq = 1'b0;
        end else begin
            if (rs) begin if (hi_run < 100000) hi_run++; end else hi_run = 0;
            if (!fs) begin if (lo_run < 100000) lo_run++; end else lo_run = 0;
            rq = rs && (hi_run > int'(rise_dly));
            fq = fs || (lo_run <= int'(fall_dly));
        end
        e.a = out_mode[1] ? (rq ^ pol_mode[0]) : ia;
        e.b = out_mode[0] ? (fq ^ pol_mode[1]) : ib;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic hold(input logic ia, input logic ib, input int n, input string tag);
        for (int k = 0; k < n; k++) step(ia, ib, tag);
    endtask

    task automatic patterns(input string tag);
        hold(1, 0, 6, tag); hold(0, 1, 6, tag); hold(1, 1, 6, tag);
        hold(0, 0, 6, tag); hold(1, 0, 2, tag); hold(0, 1, 2, tag);
        hold(1, 1, 1, tag); hold(0, 0, 5, tag);
    endtask

    // Monitor: compare one queued expectation per cycle, after the edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            n_cmp++;
            if (pwm_a !== e.a || pwm_b !== e.b) begin
                n_bad++;
                $display("FAIL %s: pwm_a,pwm_b = %b%b expected %b%b at %0t",
                         e.tag, pwm_a, pwm_b, e.a, e.b, $time);
            end
        end
    end

    initial begin
        // R1: reset state.
        hold(0, 1, 3, "R1");
        nx_rst = 1'b1;
        hold(0, 1, 6, "R1");
        // R5 and R6: basic delayed edges, complementary drive.
        hold(1, 0, 12, "R5");
        hold(0, 1, 12, "R6");
        // R7: short high pulses around the delay of 5.
        for (int l = 1; l <= 8; l++) begin
            hold(1, 0, l, "R7");
            hold(0, 1, 8, "R7");
        end
        // R8: low gaps on the falling source around the delay of 5.
        for (int g = 1; g <= 8; g++) begin
            hold(0, 0, g, "R8");
            hold(0, 1, 8, "R8");
        end
        // R9: zero delay counts.
        hold(0, 0, 30, "R9");
        nx_rd = 10'd0; nx_fd = 10'd0;
        for (int i = 1; i <= 4; i++) begin
            hold(1, 0, i, "R9");
            hold(0, 1, i, "R9");
        end
        hold(1, 1, 2, "R9");
        hold(0, 0, 30, "R9");
        // R2: every source selection.
        nx_rd = 10'd3; nx_fd = 10'd2;
        for (int s = 0; s < 4; s++) begin
            nx_src = s[1:0];
            patterns("R2");
        end
        // R3: every polarity selection.
        nx_src = 2'd2;
        for (int p = 0; p < 4; p++) begin
            nx_pol = p[1:0];
            patterns("R3");
        end
        // R4: every output selection, bypass ignores polarity.
        nx_pol = 2'd3;
        for (int o = 0; o < 4; o++) begin
            nx_out = o[1:0];
            patterns("R4");
        end
        // R10: shared source, narrow pulses and gaps near a delay of 4.
        hold(0, 0, 30, "R10");
        nx_src = 2'd0; nx_pol = 2'd2; nx_out = 2'd3;
        nx_rd = 10'd4; nx_fd = 10'd4;
        for (int l = 1; l <= 9; l++) begin
            hold(1, 0, l, "R10");
            hold(0, 1, (l % 3) + 1, "R10");
        end
        hold(0, 0, 10, "R10");
        wait (sbq.size() == 0);
        @(posedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule